// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Core

This block is a synthesizable single-port synchronous SRAM that keeps the shared data bus busy on every clock, whatever the order of reads and writes. Address, write strobe, byte enables and chip enables are captured on each rising clock edge. The write data for an operation comes later, on a fixed edge after its address. That delay is one edge when reads are flow-through and two edges when reads are pipelined. A write can therefore follow a read at once, with no idle cycle in between.

Writes wait in a short queue of pending operations until their data arrives. The array is written on the edge at which the data is sampled. A pipelined read of an address whose write data arrives on the same edge gets that data merged in, byte by byte. Each write carries 9-bit bytes, and each byte has its own enable and its own parity check. A two-bit burst counter lets a caller step through four neighbouring addresses with an advance input. The steps follow either a linear order or an interleaved order.

Read data leaves the block as a value bus plus a drive-enable. The pad ring turns the pair into a tristate bus. An asynchronous output-enable can clear the drive-enable at any moment.

Top module: `nbt_sram`

## Requirements
- R1: The block is selected on an edge only when `ce1` is 1, `ce2` is 1 and `ce_n` is 0. A selected edge with `adv` low starts a new operation at `addr`: a write if `we` is 1, otherwise a read. An edge with `adv` low and any chip enable inactive starts no operation.
- R2: With `pipe_mode` = 0, read data for a read sampled at edge k is on `rd_data`, with `rd_en` = 1, between edge k and edge k+1.
- R3: With `pipe_mode` = 1, read data for a read sampled at edge k is on `rd_data`, with `rd_en` = 1, between edge k+1 and edge k+2.
- R4: Write data for a write sampled at edge k is taken from `wdata` at edge k+1 when `pipe_mode` = 0, and at edge k+2 when `pipe_mode` = 1. `wdata` on all other edges is ignored.
- R5: Reads and writes may follow each other on every edge in any order. A read returns the latest data written to its address, including a write whose data arrives on the edge at which the read result is registered.
- R6: Bit i of `byte_we`, sampled with the address, enables write byte i (`wdata` bits 9i+8 down to 9i). Bytes whose enable is 0 keep their stored value.
- R7: An enabled write byte is correct when the XOR of its 9 bits equals `odd_par`. `par_err` is 1 for the cycle after the data edge if at least one enabled byte is wrong; otherwise it is 0. Parity of disabled bytes is ignored.
- R8: `oe_n` = 1 forces `rd_en` to 0 at once, without waiting for a clock edge. `rd_en` is also 0 in every cycle in which no read data is due.
- R9: With `burst_ilv` = 0, step n of a burst (n = 0..3, wrapping) uses the start address with its low two bits replaced by (start low bits + n) mod 4.
- R10: With `burst_ilv` = 1, step n of a burst uses the start address with its low two bits replaced by (start low bits XOR n).
- R11: An edge with `adv` = 1 during an active burst performs the next burst step, in the burst's direction and with the current `byte_we`, whatever the chip enables are. An edge with `adv` = 1 and no active burst does nothing.
- R12: An edge with `adv` low and the block deselected ends the burst. Reset ends any burst, clears pending operations and holds `rd_en` and `par_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| pipe_mode | input | 1 | 1 = pipelined reads with two-edge write delay, 0 = flow-through with one-edge delay |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| odd_par | input | 1 | Required XOR of each enabled 9-bit write byte |
| ce1 | input | 1 | Active-high chip enable |
| ce2 | input | 1 | Active-high chip enable |
| ce_n | input | 1 | Active-low chip enable |
| adv | input | 1 | Continue the current burst instead of starting an operation |
| we | input | 1 | 1 = write, 0 = read, for a new operation |
| byte_we | input | NBYTES | Per-byte write enable, sampled with the address |
| addr | input | ADDR_W | Word address for a new operation |
| wdata | input | NBYTES*BYTE_W | Late write data |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rd_data | output | NBYTES*BYTE_W | Read data, zero while not driven |
| rd_en | output | 1 | Drive enable for the read data bus |
| par_err | output | 1 | Write parity error pulse |

## Verification
The hardest case to reach is a pipelined read whose address matches a write issued one edge earlier. That write's data arrives on the very edge at which the read result is registered, and it may enable only some bytes. The stimulus gets there with directed write-read pairs to the same address and long random mixes confined to eight addresses with random byte enables. All of this runs in both timing modes and both burst orders. The bench reference applies each write on its data edge and reads the model at the cycle when the data is due, so forwarding and late-write timing are checked at the ports.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
    localparam int DEF_ADDR_W = 6;
    localparam int DEF_NBYTES = 2;
    localparam int DEF_BYTE_W = 9;
    localparam int BURST_W    = 2;
endpackage

// File: rtl/nbt_burst_addr.sv
module nbt_burst_addr #(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  step,
    input  logic              ilv,
    output logic [ADDR_W-1:0] addr_o
);
    logic [CNT_W-1:0] lo;
    logic [CNT_W-1:0] lo_lin;
    logic [CNT_W-1:0] lo_ilv;

    assign lo     = base[CNT_W-1:0];
    assign lo_lin = lo + step;
    assign lo_ilv = lo ^ step;
    assign addr_o = {base[ADDR_W-1:CNT_W], (ilv ? lo_ilv : lo_lin)};
endmodule

// File: rtl/nbt_parity_chk.sv
module nbt_parity_chk #(
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic [NBYTES*BYTE_W-1:0] data,
    input  logic [NBYTES-1:0]        be,
    input  logic                     odd,
    output logic [NBYTES-1:0]        bad
);
    for (genvar gb = 0; gb < NBYTES; gb++) begin : g_byte
        assign bad[gb] = be[gb] & ((^data[gb*BYTE_W +: BYTE_W]) != odd);
    end
endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic [NBYTES-1:0]        wr_be,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NBYTES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NBYTES*BYTE_W-1:0] rd_word
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = NBYTES * BYTE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NBYTES; i++) begin
            if (wr_be[i]) begin
                mem[wr_addr][i*BYTE_W +: BYTE_W] <= wr_data[i*BYTE_W +: BYTE_W];
            end
        end
    end

    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
    import nbt_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int NBYTES = DEF_NBYTES,
    parameter int BYTE_W = DEF_BYTE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pipe_mode,
    input  logic                     burst_ilv,
    input  logic                     odd_par,
    input  logic                     ce1,
    input  logic                     ce2,
    input  logic                     ce_n,
    input  logic                     adv,
    input  logic                     we,
    input  logic [NBYTES-1:0]        byte_we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    input  logic                     oe_n,
    output logic [NBYTES*BYTE_W-1:0] rd_data,
    output logic                     rd_en,
    output logic                     par_err
);
    localparam int DATA_W = NBYTES * BYTE_W;
    localparam int CNT_W  = BURST_W;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [NBYTES-1:0] be;
    } op_t;

    typedef struct packed {
        op_t               s1;     // op sampled on the last edge
        op_t               s2;     // op sampled two edges ago
        logic              bact;
        logic              bwr;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rdat;
        logic              rvld;
        logic              perr;
    } state_t;

    state_t state_d, state_q;

    op_t               issue;
    op_t               commit;
    logic              sel;
    logic              fwd_hit;
    logic [CNT_W-1:0]  cnt_next;
    logic [ADDR_W-1:0] adv_addr;
    logic [NBYTES-1:0] mem_be;
    logic [NBYTES-1:0] par_bad;
    logic [DATA_W-1:0] arr_rdata;
    logic [DATA_W-1:0] merged;
    logic              flow_drive;

    // observation points for the bound checker
    logic              s1_vld;
    logic              s1_wr;
    logic              commit_wr;
    logic              burst_act;
    logic [CNT_W-1:0]  burst_cnt;
    logic              pipe_rvld;

    assign cnt_next  = state_q.cnt + CNT_W'(1);
    assign commit    = pipe_mode ? state_q.s2 : state_q.s1;
    assign commit_wr = commit.vld & commit.wr;
    assign mem_be    = commit_wr ? commit.be : '0;

    nbt_burst_addr #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_baddr (
        .base   (state_q.base),
        .step   (cnt_next),
        .ilv    (burst_ilv),
        .addr_o (adv_addr)
    );

    nbt_parity_chk #(
        .NBYTES (NBYTES),
        .BYTE_W (BYTE_W)
    ) u_par (
        .data (wdata),
        .be   (commit.be),
        .odd  (odd_par),
        .bad  (par_bad)
    );

    nbt_array #(
        .ADDR_W (ADDR_W),
        .NBYTES (NBYTES),
        .BYTE_W (BYTE_W)
    ) u_arr (
        .clk     (clk),
        .wr_be   (mem_be),
        .wr_addr (commit.addr),
        .wr_data (wdata),
        .rd_addr (state_q.s1.addr),
        .rd_word (arr_rdata)
    );

    always_comb begin
        state_d = state_q;
        sel     = ce1 & ce2 & ~ce_n;
        issue   = '0;

        // operation issue and burst tracking
        if (adv) begin
            if (state_q.bact) begin
                state_d.cnt = cnt_next;
                issue.vld   = 1'b1;
                issue.wr    = state_q.bwr;
                issue.addr  = adv_addr;
                issue.be    = byte_we;
            end
        end else if (sel) begin
            state_d.bact = 1'b1;
            state_d.bwr  = we;
            state_d.base = addr;
            state_d.cnt  = '0;
            issue.vld    = 1'b1;
            issue.wr     = we;
            issue.addr   = addr;
            issue.be     = byte_we;
        end else begin
            state_d.bact = 1'b0;
        end

        // late-write queue shift
        state_d.s1 = issue;
        state_d.s2 = state_q.s1;

        // pipelined read register with same-edge write forwarding
        fwd_hit = pipe_mode & state_q.s2.vld & state_q.s2.wr &
                  (state_q.s2.addr == state_q.s1.addr);
        for (int i = 0; i < NBYTES; i++) begin
            merged[i*BYTE_W +: BYTE_W] = (fwd_hit & state_q.s2.be[i]) ?
                                         wdata[i*BYTE_W +: BYTE_W] :
                                         arr_rdata[i*BYTE_W +: BYTE_W];
        end
        state_d.rdat = merged;
        state_d.rvld = pipe_mode & state_q.s1.vld & ~state_q.s1.wr;

        // write parity flag
        state_d.perr = commit_wr & (|par_bad);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flow_drive = ~pipe_mode & state_q.s1.vld & ~state_q.s1.wr;
    assign rd_en      = ~oe_n & (pipe_mode ? state_q.rvld : flow_drive);
    assign rd_data    = rd_en ? (pipe_mode ? state_q.rdat : arr_rdata) : '0;
    assign par_err    = state_q.perr;

    assign s1_vld    = state_q.s1.vld;
    assign s1_wr     = state_q.s1.wr;
    assign burst_act = state_q.bact;
    assign burst_cnt = state_q.cnt;
    assign pipe_rvld = state_q.rvld;
endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pipe_mode,
    input logic             ce1,
    input logic             ce2,
    input logic             ce_n,
    input logic             adv,
    input logic             par_err,
    input logic             s1_vld,
    input logic             s1_wr,
    input logic             commit_wr,
    input logic             burst_act,
    input logic [CNT_W-1:0] burst_cnt,
    input logic             pipe_rvld
);
    // R1
    new_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && ce1 && ce2 && !ce_n) |=> (s1_vld && burst_act && burst_cnt == '0));

    // R3
    pipe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && pipe_rvld) |-> $past(s1_vld && !s1_wr));

    // R7
    perr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> $past(commit_wr));

    // R11
    idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !burst_act) |=> !s1_vld);

    // R12
    deselect_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !(ce1 && ce2 && !ce_n)) |=> (!burst_act && !s1_vld));
endmodule

bind nbt_sram nbt_sram_chk #(.CNT_W(2)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .ce1       (ce1),
    .ce2       (ce2),
    .ce_n      (ce_n),
    .adv       (adv),
    .par_err   (par_err),
    .s1_vld    (s1_vld),
    .s1_wr     (s1_wr),
    .commit_wr (commit_wr),
    .burst_act (burst_act),
    .burst_cnt (burst_cnt),
    .pipe_rvld (pipe_rvld)
);

// File: tb/nbt_sram_tb.sv
`timescale 1ns/1ps
module nbt_sram_tb;
    localparam int AW = 6;
    localparam int NB = 2;
    localparam int BW = 9;
    localparam int DW = NB * BW;
    localparam int DEPTH = 1 << AW;
    localparam int SLOTS = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pipe_mode, burst_ilv, odd_par;
    logic          ce1, ce2, ce_n, adv, we, oe_n;
    logic [NB-1:0] byte_we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rd_data;
    logic          rd_en, par_err;

    always #4 clk = ~clk;

    nbt_sram u_dut (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
        .odd_par(odd_par), .ce1(ce1), .ce2(ce2), .ce_n(ce_n), .adv(adv), .we(we),
        .byte_we(byte_we), .addr(addr), .wdata(wdata), .oe_n(oe_n),
        .rd_data(rd_data), .rd_en(rd_en), .par_err(par_err)
    );

    int checks = 0;
    int fails  = 0;
    string cur_tag = "R12";

    // reference model
    logic [DW-1:0] mm [DEPTH];
    logic          wd_v  [SLOTS];
    logic [AW-1:0] wd_a  [SLOTS];
    logic [NB-1:0] wd_be [SLOTS];
    logic [DW-1:0] wd_w  [SLOTS];
    logic          rd_v  [SLOTS];
    logic [AW-1:0] rd_a  [SLOTS];
    int            k = 0;
    logic          m_bact;
    logic          m_bwr;
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    logic          exp_err;
    logic [NB-1:0] bad_mask = '0;

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, expv, $time);
        end
    endtask

    function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] b, input logic [1:0] n);
        logic [1:0] lo;
        lo = burst_ilv ? (b[1:0] ^ n) : (b[1:0] + n);
        return {b[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] make_word();
        logic [DW-1:0] w;
        for (int b = 0; b < NB; b++) begin
            logic [7:0] v;
            logic       p;
            v = 8'($urandom);
            p = (^v) ^ odd_par ^ bad_mask[b];
            w[b*BW +: BW] = {p, v};
        end
        return w;
    endfunction

    task automatic clear_model();
        for (int i = 0; i < SLOTS; i++) begin
            wd_v[i] = 1'b0;
            rd_v[i] = 1'b0;
        end
        m_bact  = 1'b0;
        m_bwr   = 1'b0;
        m_base  = '0;
        m_cnt   = '0;
        exp_err = 1'b0;
    endtask

    task automatic model_edge();
        int s;
        logic          op_v;
        logic          op_w;
        logic [AW-1:0] op_a;
        s = k % SLOTS;
        exp_err = 1'b0;
        if (wd_v[s]) begin
            for (int b = 0; b < NB; b++) begin
                if (wd_be[s][b]) begin
                    mm[wd_a[s]][b*BW +: BW] = wd_w[s][b*BW +: BW];
                    if ((^wd_w[s][b*BW +: BW]) != odd_par) exp_err = 1'b1;
                end
            end
            wd_v[s] = 1'b0;
        end
        op_v = 1'b0;
        op_w = 1'b0;
        op_a = '0;
        if (adv) begin
            if (m_bact) begin
                m_cnt = m_cnt + 2'd1;
                op_v  = 1'b1;
                op_w  = m_bwr;
                op_a  = step_addr(m_base, m_cnt);
            end
        end else if (ce1 && ce2 && !ce_n) begin
            m_bact = 1'b1;
            m_bwr  = we;
            m_base = addr;
            m_cnt  = '0;
            op_v   = 1'b1;
            op_w   = we;
            op_a   = addr;
        end else begin
            m_bact = 1'b0;
        end
        if (op_v && op_w) begin
            int t;
            t = (k + (pipe_mode ? 2 : 1)) % SLOTS;
            wd_v[t]  = 1'b1;
            wd_a[t]  = op_a;
            wd_be[t] = byte_we;
            wd_w[t]  = make_word();
            bad_mask = '0;
        end
        if (op_v && !op_w) begin
            int t;
            t = (k + (pipe_mode ? 1 : 0)) % SLOTS;
            rd_v[t] = 1'b1;
            rd_a[t] = op_a;
        end
    endtask

    task automatic check_outputs();
        int s;
        s = k % SLOTS;
        if (rd_v[s] && !oe_n) begin
            chk(rd_en === 1'b1, cur_tag, "rd_en on read", 32'(rd_en), 32'd1);
            chk(rd_data === mm[rd_a[s]], cur_tag, "read data", 32'(rd_data), 32'(mm[rd_a[s]]));
        end else begin
            chk(rd_en === 1'b0, rd_v[s] ? "R8" : cur_tag, "rd_en idle", 32'(rd_en), 32'd0);
        end
        rd_v[s] = 1'b0;
        chk(par_err === exp_err, "R7", "par_err", 32'(par_err), 32'(exp_err));
    endtask

    task automatic tick();
        int nk;
        nk = k + 1;
        if (wd_v[nk % SLOTS]) wdata = wd_w[nk % SLOTS];
        else wdata = DW'($urandom);
        @(posedge clk);
        k = nk;
        model_edge();
        #2;
        check_outputs();
        @(negedge clk);
    endtask

    task automatic op_wr(input logic [AW-1:0] a, input logic [NB-1:0] be);
        ce1 = 1'b1; ce2 = 1'b1; ce_n = 1'b0; adv = 1'b0;
        we = 1'b1; byte_we = be; addr = a;
        tick();
    endtask

    task automatic op_rd(input logic [AW-1:0] a);
        ce1 = 1'b1; ce2 = 1'b1; ce_n = 1'b0; adv = 1'b0;
        we = 1'b0; byte_we = '0; addr = a;
        tick();
    endtask

    task automatic op_adv(input logic [NB-1:0] be, input int ce_off);
        ce1 = (ce_off != 0); ce2 = (ce_off != 1); ce_n = (ce_off == 2);
        adv = 1'b1; we = 1'($urandom); byte_we = be; addr = AW'($urandom);
        tick();
    endtask

    task automatic op_idle(input int which);
        ce1 = (which != 0); ce2 = (which != 1); ce_n = (which == 2);
        adv = 1'b0; we = 1'($urandom); byte_we = NB'($urandom); addr = AW'($urandom);
        tick();
    endtask

    task automatic drain();
        for (int i = 0; i < 3; i++) op_idle(0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ce1 = 1'b0; ce2 = 1'b1; ce_n = 1'b0; adv = 1'b0; we = 1'b0;
        byte_we = '0; addr = '0; oe_n = 1'b0; wdata = '0;
        @(negedge clk);
        @(negedge clk);
        // R12: after reset nothing is driven or flagged
        chk(rd_en === 1'b0, "R12", "rd_en in reset", 32'(rd_en), 32'd0);
        chk(par_err === 1'b0, "R12", "par_err in reset", 32'(par_err), 32'd0);
        rst_n = 1'b1;
        clear_model();
    endtask

    task automatic run_config(input int cfg);
        pipe_mode = cfg[0];
        burst_ilv = cfg[1];
        odd_par   = cfg[0] ^ cfg[1];
        do_reset();

        // fill and read back every word
        cur_tag = "R4";
        for (int a = 0; a < DEPTH; a++) op_wr(AW'(a), 2'b11);
        cur_tag = pipe_mode ? "R3" : "R2";
        for (int a = 0; a < DEPTH; a++) op_rd(AW'(a));
        drain();

        // R1: each chip enable alone deselects
        cur_tag = "R1";
        op_idle(0); op_idle(1); op_idle(2);
        op_rd(6'd9);
        op_idle(2);
        drain();

        // R4: back-to-back writes, then reads
        cur_tag = "R4";
        op_wr(6'd20, 2'b11); op_wr(6'd21, 2'b11); op_wr(6'd22, 2'b11);
        op_rd(6'd20); op_rd(6'd21); op_rd(6'd22);
        drain();

        // R5: reads right behind writes to the same address
        cur_tag = "R5";
        op_wr(6'd5, 2'b11); op_rd(6'd5);
        op_wr(6'd5, 2'b01); op_rd(6'd5); op_rd(6'd5);
        op_rd(6'd6); op_wr(6'd6, 2'b10); op_rd(6'd6); op_wr(6'd7, 2'b11); op_rd(6'd7);
        drain();

        // R6: partial byte writes
        cur_tag = "R6";
        op_wr(6'd30, 2'b11); op_wr(6'd30, 2'b01); op_wr(6'd30, 2'b10);
        op_wr(6'd30, 2'b00); op_rd(6'd30);
        drain();

        // R7: parity on enabled and disabled bytes
        cur_tag = "R7";
        bad_mask = 2'b01; op_wr(6'd31, 2'b01);
        bad_mask = 2'b10; op_wr(6'd31, 2'b01);
        bad_mask = 2'b11; op_wr(6'd32, 2'b11);
        bad_mask = 2'b10; op_wr(6'd32, 2'b10);
        drain();

        // R8: output enable held high, then toggled between edges
        cur_tag = "R8";
        oe_n = 1'b1;
        op_rd(6'd40);
        if (pipe_mode) op_idle(1);
        oe_n = 1'b0;
        op_rd(6'd41);
        if (pipe_mode) op_idle(1);
        oe_n = 1'b1;
        #1;
        chk(rd_en === 1'b0, "R8", "async oe off", 32'(rd_en), 32'd0);
        oe_n = 1'b0;
        #1;
        chk(rd_en === 1'b1, "R8", "async oe on", 32'(rd_en), 32'd1);
        chk(rd_data === mm[6'd41], "R8", "data after oe", 32'(rd_data), 32'(mm[6'd41]));
        drain();

        // R9 / R10: burst write then burst read from a mid-group start
        cur_tag = burst_ilv ? "R10" : "R9";
        op_wr(6'h16, 2'b11);
        for (int i = 0; i < 4; i++) op_adv(2'b11, 3);
        op_rd(6'h16);
        for (int i = 0; i < 4; i++) op_adv(2'b00, 3);
        for (int a = 16; a < 24; a++) op_rd(AW'(a));
        drain();

        // R11: advance ignores chip enables; advance without burst is idle
        cur_tag = "R11";
        op_rd(6'h2d);
        op_adv(2'b00, 0); op_adv(2'b00, 1); op_adv(2'b00, 2);
        op_idle(1);
        op_adv(2'b11, 3); op_adv(2'b11, 3);
        drain();

        // R12: deselect ends a write burst
        cur_tag = "R12";
        op_wr(6'h3a, 2'b11);
        op_idle(2);
        op_adv(2'b11, 3);
        op_rd(6'h3a); op_rd(6'h3b);
        drain();

        // R5: random mix on a narrow window
        cur_tag = "R5";
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom_range(0, 9);
            oe_n = ($urandom_range(0, 15) == 0);
            if (r <= 2) begin
                if ($urandom_range(0, 5) == 0) bad_mask = NB'($urandom_range(1, 3));
                op_wr(AW'($urandom_range(0, 7)), NB'($urandom));
            end else if (r <= 5) begin
                op_rd(AW'($urandom_range(0, 7)));
            end else if (r <= 7) begin
                op_adv(NB'($urandom), $urandom_range(0, 3));
            end else begin
                op_idle($urandom_range(0, 2));
            end
        end
        oe_n = 1'b0;
        drain();
    endtask

    initial begin
        rst_n = 1'b0;
        pipe_mode = 1'b0; burst_ilv = 1'b0; odd_par = 1'b0;
        ce1 = 1'b0; ce2 = 1'b0; ce_n = 1'b1; adv = 1'b0; we = 1'b0;
        byte_we = '0; addr = '0; wdata = '0; oe_n = 1'b0;
        clear_model();
        @(negedge clk);
        for (int cfg = 0; cfg < 4; cfg++) run_config(cfg);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", 200000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule